// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

This block turns parallel left and right audio samples from an upstream decoder into a serial stream. It generates its own bit clock and word clock from the system clock and drives a primary data line and a secondary data line. A frame holds two 32-bit channel slots. Within each slot the sample sits in one of five placements: left-aligned full width, right-aligned at full width, 20 bits or 16 bits, or the I2S placement with its one-bit lag.

Two select pins choose among the four justified layouts. A separate override input forces I2S framing and takes priority over the pins. Format, samples and validity flags are captured once per frame, so a frame never mixes two layouts. While the upstream error indication is high, both data lines are held low. Data resumes at the next slot boundary after the indication clears. The secondary line can either repeat the sample data or carry the validity flag of the channel in the current slot.

Top module: `sao_formatter`

## Requirements
- R1: The bit clock has a period of 2*HALF_DIV system clocks (4 by default). Data lines and the word clock change only on the system clock edge where the bit clock falls. In reset the bit clock is high and the word clock and both data lines are low.
- R2: A frame is 64 bit periods. The word clock is high for bit periods 0 to 31 (first slot) and low for 32 to 63 (second slot).
- R3: With the override low and select code 00, the full 24-bit sample is sent MSB first starting at slot position 0.
- R4: With the override low and select code 01, the 24-bit sample ends with its LSB at slot position 31.
- R5: With the override low and select code 10, sample bits 23 down to 4 are sent, ending at slot position 31. Bits 3 to 0 are dropped.
- R6: With the override low and select code 11, sample bits 23 down to 8 are sent, ending at slot position 31. Bits 7 to 0 are dropped.
- R7: With the override high, the select pins are ignored. The right sample goes in the first slot and the left sample in the second, with the MSB at slot position 1.
- R8: In the four justified layouts, the left sample goes in the first slot and the right sample in the second.
- R9: Every slot position not carrying a sample bit drives 0.
- R10: A bit period whose preceding falling edge saw the error input high drives 0 on both data lines. After the error input is seen low, data stays 0 until the next slot boundary (slot position 0), then starts.
- R11: The select code, override, samples and validity flags are sampled at the falling edge that starts slot position 0 of the first slot. They are held for the whole frame.
- R12: With the secondary-line mode input low, the secondary line equals the primary line. With it high, the secondary line carries the captured validity flag of the channel in the current slot, gated as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_l | input | SAMPLE_W | Left sample |
| smp_r | input | SAMPLE_W | Right sample |
| fmt_sel | input | 2 | Justified layout select code |
| i2s_ovr | input | 1 | Forces I2S framing, overriding fmt_sel |
| err | input | 1 | Upstream error indication, high blocks data |
| vld_l | input | 1 | Left-channel validity flag |
| vld_r | input | 1 | Right-channel validity flag |
| vmode | input | 1 | Secondary line carries validity flag when high |
| bclk | output | 1 | Generated bit clock |
| wclk | output | 1 | Generated word clock |
| dout | output | 1 | Primary serial data |
| dout2 | output | 1 | Secondary serial data or validity flag |

## Verification
The bench goes after the slot edges of each layout: the first and last positions of each window, and the dropped low-order bits in the 20- and 16-bit layouts. A design with an off-by-one window would shift every sample by one bit or leak a dropped LSB into the slot. It also drops the error input in the middle of a slot and checks that data stays silent until the next slot boundary, where a careless start would emit a truncated sample. It changes format and samples mid-frame, which would show up as a mixed-layout frame if capture were not frame-aligned. With the override set it checks that channel order reverses, which a design that only moved the MSB position would miss.

// File: rtl/sao_pkg.sv
package sao_pkg;

   typedef enum logic [2:0] {
      FMT_LJ      = 3'd0,
      FMT_RJ_FULL = 3'd1,
      FMT_RJ20    = 3'd2,
      FMT_RJ16    = 3'd3,
      FMT_I2S     = 3'd4
   } fmt_e;

   localparam int NUM_FMT = 5;
   localparam int FMT_SPACE = 8;

   // override wins over the pin code
   function automatic fmt_e fmt_decode(input logic [1:0] sel, input logic ovr);
      fmt_e f;
      if (ovr) f = FMT_I2S;
      else begin
         case (sel)
            2'b00:   f = FMT_LJ;
            2'b01:   f = FMT_RJ_FULL;
            2'b10:   f = FMT_RJ20;
            default: f = FMT_RJ16;
         endcase
      end
      return f;
   endfunction

   function automatic int fmt_bits(input int f, input int sample_w);
      int n;
      case (f)
         2:       n = 20;
         3:       n = 16;
         default: n = sample_w;
      endcase
      return n;
   endfunction

   // slot position carrying the MSB
   function automatic int fmt_first(input int f, input int slot_bits, input int sample_w);
      int s;
      case (f)
         0:       s = 0;
         4:       s = 1;
         default: s = slot_bits - fmt_bits(f, sample_w);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sao_bitclk.sv
module sao_bitclk #(
   parameter  int HALF_DIV   = 2,
   parameter  int FRAME_BITS = 64,
   localparam int FW         = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          bclk,
   output logic          fall_stb,
   output logic [FW-1:0] nxt_bit
);
   localparam int DIV = 2 * HALF_DIV;
   localparam int DW  = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] D_LAST = DW'(DIV - 1);
   localparam logic [DW-1:0] D_MID  = DW'(HALF_DIV - 1);

   logic [DW-1:0] dcnt;
   logic [FW-1:0] bit_q;

   assign fall_stb = (dcnt == D_LAST);
   assign nxt_bit  = bit_q + FW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dcnt  <= D_LAST;
         bclk  <= 1'b1;
         bit_q <= FW'(FRAME_BITS - 1);
      end else if (fall_stb) begin
         dcnt  <= '0;
         bclk  <= 1'b0;
         bit_q <= nxt_bit;
      end else begin
         dcnt <= dcnt + DW'(1);
         if (dcnt == D_MID) bclk <= 1'b1;
      end
   end
endmodule

// File: rtl/sao_frame_latch.sv
module sao_frame_latch
   import sao_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  fmt_e                fmt_in,
   input  logic [SAMPLE_W-1:0] l_in,
   input  logic [SAMPLE_W-1:0] r_in,
   input  logic                vl_in,
   input  logic                vr_in,
   output fmt_e                fmt_cur,
   output logic [SAMPLE_W-1:0] l_cur,
   output logic [SAMPLE_W-1:0] r_cur,
   output logic                vl_cur,
   output logic                vr_cur
);
   fmt_e                fmt_q;
   logic [SAMPLE_W-1:0] l_q, r_q;
   logic                vl_q, vr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q <= FMT_LJ;
         l_q   <= '0;
         r_q   <= '0;
         vl_q  <= 1'b0;
         vr_q  <= 1'b0;
      end else if (load) begin
         fmt_q <= fmt_in;
         l_q   <= l_in;
         r_q   <= r_in;
         vl_q  <= vl_in;
         vr_q  <= vr_in;
      end
   end

   // the frame's first bit already uses the fresh values
   assign fmt_cur = load ? fmt_in : fmt_q;
   assign l_cur   = load ? l_in   : l_q;
   assign r_cur   = load ? r_in   : r_q;
   assign vl_cur  = load ? vl_in  : vl_q;
   assign vr_cur  = load ? vr_in  : vr_q;
endmodule

// File: rtl/sao_slot_mux.sv
module sao_slot_mux
   import sao_pkg::*;
#(
   parameter  int SAMPLE_W  = 24,
   parameter  int SLOT_BITS = 32,
   localparam int PW        = $clog2(SLOT_BITS),
   localparam int IW        = $clog2(SAMPLE_W)
) (
   input  fmt_e                fmt,
   input  logic [SAMPLE_W-1:0] smp,
   input  logic [PW-1:0]       pos,
   output logic                bit_o
);
   logic [FMT_SPACE-1:0] cand;

   for (genvar f = 0; f < FMT_SPACE; f++) begin : g_fmt
      if (f < NUM_FMT) begin : g_used
         localparam int FIRST = fmt_first(f, SLOT_BITS, SAMPLE_W);
         localparam int NBITS = fmt_bits(f, SAMPLE_W);
         logic          cand_b;
         logic [IW-1:0] idx;
         int            off;
         always_comb begin
            off    = int'(pos) - FIRST;
            idx    = IW'(SAMPLE_W - 1 - off);
            cand_b = 1'b0;
            if (off >= 0 && off < NBITS) cand_b = smp[idx];
         end
         assign cand[f] = cand_b;
      end else begin : g_unused
         assign cand[f] = 1'b0;
      end
   end

   assign bit_o = cand[fmt];
endmodule

// File: rtl/sao_formatter.sv
module sao_formatter
   import sao_pkg::*;
#(
   parameter int SAMPLE_W  = 24,
   parameter int SLOT_BITS = 32,
   parameter int HALF_DIV  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_l,
   input  logic [SAMPLE_W-1:0] smp_r,
   input  logic [1:0]          fmt_sel,
   input  logic                i2s_ovr,
   input  logic                err,
   input  logic                vld_l,
   input  logic                vld_r,
   input  logic                vmode,
   output logic                bclk,
   output logic                wclk,
   output logic                dout,
   output logic                dout2
);
   localparam int FRAME_BITS = 2 * SLOT_BITS;
   localparam int FW         = $clog2(FRAME_BITS);
   localparam int PW         = $clog2(SLOT_BITS);

   if (SAMPLE_W < 20) begin : g_bad_width
      $error("SAMPLE_W must cover the 20-bit layout");
   end
   if (SLOT_BITS < SAMPLE_W + 1) begin : g_bad_slot
      $error("SLOT_BITS must exceed SAMPLE_W for the one-bit lag layout");
   end
   if ((1 << PW) != SLOT_BITS) begin : g_bad_pow2
      $error("SLOT_BITS must be a power of two");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic                fall_stb;
   logic [FW-1:0]       nxt_bit;
   logic [PW-1:0]       pos;
   logic                second_slot;
   fmt_e                fmt_now, fmt_cur;
   logic [SAMPLE_W-1:0] l_cur, r_cur, chan_smp;
   logic                vl_cur, vr_cur, chan_vld, is_left;
   logic                ser_bit, en_q, en_nx;

   sao_bitclk #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk     (bclk),
      .fall_stb (fall_stb),
      .nxt_bit  (nxt_bit)
   );

   assign pos         = nxt_bit[PW-1:0];
   assign second_slot = nxt_bit[FW-1];
   assign fmt_now     = fmt_decode(fmt_sel, i2s_ovr);

   sao_frame_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fall_stb && (nxt_bit == '0)),
      .fmt_in  (fmt_now),
      .l_in    (smp_l),
      .r_in    (smp_r),
      .vl_in   (vld_l),
      .vr_in   (vld_r),
      .fmt_cur (fmt_cur),
      .l_cur   (l_cur),
      .r_cur   (r_cur),
      .vl_cur  (vl_cur),
      .vr_cur  (vr_cur)
   );

   // I2S puts right channel in the first slot
   assign is_left  = (fmt_cur == FMT_I2S) ? second_slot : !second_slot;
   assign chan_smp = is_left ? l_cur  : r_cur;
   assign chan_vld = is_left ? vl_cur : vr_cur;

   sao_slot_mux #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_mux (
      .fmt   (fmt_cur),
      .smp   (chan_smp),
      .pos   (pos),
      .bit_o (ser_bit)
   );

   assign en_nx = !err && (en_q || (pos == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         wclk  <= 1'b0;
         dout  <= 1'b0;
         dout2 <= 1'b0;
      end else if (fall_stb) begin
         en_q  <= en_nx;
         wclk  <= !second_slot;
         dout  <= en_nx && ser_bit;
         dout2 <= en_nx && (vmode ? chan_vld : ser_bit);
      end
   end
endmodule

// File: rtl/sao_formatter_chk.sv
module sao_formatter_chk (
   input logic clk,
   input logic rst_n,
   input logic bclk,
   input logic wclk,
   input logic dout,
   input logic dout2,
   input logic err,
   input logic vmode
);
   p_dout_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> ($past(bclk) && !bclk));

   p_wclk_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wclk != $past(wclk)) |-> ($past(bclk) && !bclk));

   p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bclk) && !bclk && $past(err)) |-> (!dout && !dout2));

   p_dout2_copy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bclk) && !bclk && !$past(vmode)) |-> (dout2 == dout));
endmodule

bind sao_formatter sao_formatter_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .bclk  (bclk),
   .wclk  (wclk),
   .dout  (dout),
   .dout2 (dout2),
   .err   (err),
   .vmode (vmode)
);

// File: tb/sao_formatter_bench.sv
module sao_formatter_bench;
   localparam int SW    = 24;
   localparam int SLOT  = 32;
   localparam int FRAME = 64;
   localparam int NRISE = FRAME * 60;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, i2s_ovr, err, vld_l, vld_r, vmode;
   logic [SW-1:0] smp_l, smp_r;
   logic [1:0]    fmt_sel;
   logic          bclk, wclk, dout, dout2;

   int checks = 0;
   int fails  = 0;

   sao_formatter u_sao_formatter (
      .clk(clk), .rst_n(rst_n), .smp_l(smp_l), .smp_r(smp_r),
      .fmt_sel(fmt_sel), .i2s_ovr(i2s_ovr), .err(err),
      .vld_l(vld_l), .vld_r(vld_r), .vmode(vmode),
      .bclk(bclk), .wclk(wclk), .dout(dout), .dout2(dout2)
   );

   task automatic chk(input string tag, input int k, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at bit %0d: actual=%0b expected=%0b", tag, k, act, exp);
      end
   endtask

   // expected bit at slot position p (R3, R4, R5, R6, R7, R9)
   function automatic logic exp_bit(input logic [1:0] sel, input logic ovr,
                                    input logic [SW-1:0] s, input int p);
      int lo, hi;
      if (ovr) begin lo = 1; hi = 24; end
      else begin
         case (sel)
            2'b00:   begin lo = 0;  hi = 23; end
            2'b01:   begin lo = 8;  hi = 31; end
            2'b10:   begin lo = 12; hi = 31; end
            default: begin lo = 16; hi = 31; end
         endcase
      end
      if (p < lo || p > hi) return 1'b0;
      return s[SW-1-(p-lo)];
   endfunction

   function automatic string fmt_tag(input logic [1:0] sel, input logic ovr);
      if (ovr) return "R7";
      case (sel)
         2'b00:   return "R3,R8";
         2'b01:   return "R4,R8";
         2'b10:   return "R5,R9";
         default: return "R6,R9";
      endcase
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic          prev_b, en, left, eb, ev;
      logic [1:0]    f_sel;
      logic          f_ovr, f_vl, f_vr;
      logic [SW-1:0] f_l, f_r;
      int            k, pos, p, slot, cyc, last_rise;
      string         tag;

      void'($urandom(32'd4711));
      rst_n = 1'b0; err = 1'b1; i2s_ovr = 1'b0; fmt_sel = 2'b00;
      smp_l = 24'hA5C3F1; smp_r = 24'h5A3C0F; vld_l = 1'b1; vld_r = 1'b0; vmode = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset bclk", -1, bclk, 1'b1);
      chk("R1 reset wclk", -1, wclk, 1'b0);
      chk("R1 reset dout", -1, dout, 1'b0);
      chk("R1 reset dout2", -1, dout2, 1'b0);
      rst_n = 1'b1;

      prev_b = 1'b1; k = 0; en = 1'b0; cyc = 0; last_rise = 0;
      f_sel = 0; f_ovr = 0; f_l = 0; f_r = 0; f_vl = 0; f_vr = 0;
      while (k < NRISE) begin
         @(negedge clk);
         cyc++;
         if (bclk && !prev_b) begin
            pos  = k % FRAME;
            slot = pos / SLOT;
            p    = pos % SLOT;
            if (k > 0) chk("R1 bclk period", k, 1'b1, (cyc - last_rise) == 4);
            last_rise = cyc;
            // R11 frame-aligned capture of everything
            if (pos == 0) begin
               f_sel = fmt_sel; f_ovr = i2s_ovr; f_l = smp_l; f_r = smp_r;
               f_vl = vld_l; f_vr = vld_r;
            end
            // R10 start gating
            en   = !err && (en || p == 0);
            left = f_ovr ? (slot == 1) : (slot == 0);
            eb   = en && exp_bit(f_sel, f_ovr, left ? f_l : f_r, p);
            ev   = en && (left ? f_vl : f_vr);
            tag  = en ? fmt_tag(f_sel, f_ovr) : "R10";
            chk("R2 wclk", k, wclk, slot == 0);
            chk({tag, " R11 dout"}, k, dout, eb);
            chk(vmode ? "R12 validity" : "R12 copy", k, dout2, vmode ? ev : eb);

            // stimulus, applied after the compare
            if (k == 100) err = 1'b0;             // mid-slot release (R10)
            if (k == 1500) err = 1'b1;
            if (k == 1543) err = 1'b0;
            if (k < 256) begin
               // directed: fill with ones to expose window edges (R9)
               if (pos == 40) begin
                  fmt_sel = 2'(k / 64);
                  smp_l = 24'hFFFFFF; smp_r = 24'h800001;
               end
            end else if (pos == 40) begin
               fmt_sel = 2'($urandom_range(0, 3));
               i2s_ovr = ($urandom_range(0, 3) == 0);
               smp_l   = 24'($urandom);
               smp_r   = 24'($urandom);
               vld_l   = 1'($urandom);
               vld_r   = 1'($urandom);
               vmode   = ($urandom_range(0, 2) == 0);
            end else if (pos == 50) begin
               // mid-frame changes must not reach the current frame (R11)
               fmt_sel = ~fmt_sel;
               smp_l   = ~smp_l;
            end
            k++;
         end
         prev_b = bclk;
      end
      summary();
      $finish;
   end
endmodule